// File: doc/BRIEF.md
# PWM Emergency Break Controller

This block sits between a multi-channel PWM generator and the output pins, and gives hardware a fast path to stop the power stage. An active-low break pin, once enabled, trips a sticky break-active flag. While the flag is set, the block asserts hold signals that keep the timer's counter, its auto-reload value, every duty-cycle register and its mode configuration at their reset values. Each gated PWM output is then replaced by one bit of a programmable safe-level pattern.

The pin is brought into the clock domain through a short synchronizer chain. The flag stays set after the pin returns high, and only a software clear pulse removes it. A one-cycle interrupt pulse marks each transition into the tripped state. While the flag is clear, the PWM inputs pass straight to the outputs through a multiplexer with no register in the path.

Top module: `pwm_break_ctrl`

## Requirements
- R1: After reset, brk_active_o, brk_irq_o and every hold output are 0, and pwm_o equals pwm_i.
- R2: With brk_en_i at 1, a low level on brk_n_i sets brk_active_o on the third rising clock edge after the pin goes low (two synchronizer stages, then the flag register), and not earlier.
- R3: With brk_en_i at 0, a low level on brk_n_i has no effect: brk_active_o stays 0 and pwm_o keeps following pwm_i.
- R4: Once set, brk_active_o stays 1 after the pin returns high and after brk_en_i drops to 0, until a clear is applied.
- R5: A brk_clr_i pulse while the synchronized pin is high clears brk_active_o at that clock edge.
- R6: A brk_clr_i pulse while the synchronized pin is still low and brk_en_i is 1 leaves brk_active_o at 1, because setting wins over clearing.
- R7: cnt_hold_o, arr_hold_o, mode_hold_o and every bit of dcr_hold_o equal brk_active_o at all times.
- R8: While brk_active_o is 1, pwm_o[i] equals brk_pat_i[i] for every channel i, whatever pwm_i holds.
- R9: While brk_active_o is 0, pwm_o equals pwm_i in the same cycle, with no register delay.
- R10: brk_irq_o is a single-cycle pulse, asserted in the cycle in which brk_active_o first becomes 1. No further pulse occurs while the flag stays set, even if the pin toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_n_i | input | 1 | Asynchronous break pin, active low |
| brk_en_i | input | 1 | Enables break detection |
| brk_pat_i | input | NCH | Level each output takes during break, bit i for channel i |
| brk_clr_i | input | 1 | Software clear pulse for the break flag |
| pwm_i | input | NCH | Normal PWM levels from the generator |
| pwm_o | output | NCH | Gated PWM levels to the pins |
| brk_active_o | output | 1 | Sticky break-active flag |
| cnt_hold_o | output | 1 | Holds the PWM counter at its reset value |
| arr_hold_o | output | 1 | Holds the auto-reload value at reset |
| dcr_hold_o | output | NCH | Holds each duty-cycle register at reset |
| mode_hold_o | output | 1 | Returns the PWM mode to its reset value |
| brk_irq_o | output | 1 | One-cycle interrupt pulse on a break event |

## Verification
The bench builds the block with its defaults of four channels and two synchronizer stages. Four channels leave only 16 safe-level patterns and 16 PWM input combinations, so it sweeps all 256 pairs both with the flag clear and with the flag set. The two-stage chain makes the trip latency short enough to sample each edge around it. Clears with the pin high and with the pin low, disabled detection, and pin toggles while tripped are each driven in a directed sequence.

// File: rtl/pwm_brk_pkg.sv
package pwm_brk_pkg;

  typedef enum logic {
    BRK_IDLE    = 1'b0,
    BRK_TRIPPED = 1'b1
  } brk_state_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/pwm_brk_sync.sv
module pwm_brk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  output logic pin_n_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= pin_n_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], pin_n_i};
      end
    end
  endgenerate

  assign pin_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_brk_latch.sv
module pwm_brk_latch
  import pwm_brk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic pin_low_i,
  input  logic clr_i,
  output logic active_o,
  output logic irq_o
);

  brk_state_e state_q;
  logic       set_req;

  assign set_req = en_i & pin_low_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BRK_IDLE;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= set_req && (state_q == BRK_IDLE);
      if (set_req)    state_q <= BRK_TRIPPED;
      else if (clr_i) state_q <= BRK_IDLE;
    end
  end

  assign active_o = (state_q == BRK_TRIPPED);

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (en_i && pin_low_i) |=> active_o);

  p_noen_r3: assert property (@(posedge clk) disable iff (rst)
    (!active_o && !en_i) |=> !active_o);

  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (active_o && !clr_i) |=> active_o);

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (active_o && clr_i && !(en_i && pin_low_i)) |=> !active_o);

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (active_o && !$past(active_o)));

  p_irq_single_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

endmodule

// File: rtl/pwm_brk_gate.sv
module pwm_brk_gate #(
  parameter int unsigned NCH = 4
) (
  input  logic           active_i,
  input  logic [NCH-1:0] pat_i,
  input  logic [NCH-1:0] pwm_i,
  output logic [NCH-1:0] pwm_o
);

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      assign pwm_o[ch] = active_i ? pat_i[ch] : pwm_i[ch];
    end
  endgenerate

endmodule

// File: rtl/pwm_break_ctrl.sv
module pwm_break_ctrl
  import pwm_brk_pkg::*;
#(
  parameter int unsigned NCH         = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           brk_n_i,
  input  logic           brk_en_i,
  input  logic [NCH-1:0] brk_pat_i,
  input  logic           brk_clr_i,
  input  logic [NCH-1:0] pwm_i,
  output logic [NCH-1:0] pwm_o,
  output logic           brk_active_o,
  output logic           cnt_hold_o,
  output logic           arr_hold_o,
  output logic [NCH-1:0] dcr_hold_o,
  output logic           mode_hold_o,
  output logic           brk_irq_o
);

  localparam int unsigned STAGES_USED =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic pin_n_sync;
  logic active;

  pwm_brk_sync #(.STAGES(STAGES_USED)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_n_i (brk_n_i),
    .pin_n_o (pin_n_sync)
  );

  pwm_brk_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .en_i      (brk_en_i),
    .pin_low_i (~pin_n_sync),
    .clr_i     (brk_clr_i),
    .active_o  (active),
    .irq_o     (brk_irq_o)
  );

  pwm_brk_gate #(.NCH(NCH)) u_gate (
    .active_i (active),
    .pat_i    (brk_pat_i),
    .pwm_i    (pwm_i),
    .pwm_o    (pwm_o)
  );

  assign brk_active_o = active;
  assign cnt_hold_o   = active;
  assign arr_hold_o   = active;
  assign mode_hold_o  = active;

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_dcr
      assign dcr_hold_o[ch] = active;
    end
  endgenerate

  p_hold_rise_r7: assert property (@(posedge clk) disable iff (rst)
    brk_irq_o |-> (cnt_hold_o && arr_hold_o && mode_hold_o && (&dcr_hold_o)));

  p_gate_r8: assert property (@(posedge clk) disable iff (rst)
    brk_irq_o |-> (pwm_o == brk_pat_i));

endmodule

// File: tb/pwm_break_ctrl_tb_top.sv
module pwm_break_ctrl_tb_top;

  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst;
  logic           brk_n;
  logic           brk_en;
  logic [NCH-1:0] brk_pat;
  logic           brk_clr;
  logic [NCH-1:0] pwm_in;
  logic [NCH-1:0] pwm_out;
  logic           active;
  logic           cnt_hold, arr_hold, mode_hold, irq;
  logic [NCH-1:0] dcr_hold;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwm_break_ctrl #(.NCH(NCH), .SYNC_STAGES(2)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .brk_n_i      (brk_n),
    .brk_en_i     (brk_en),
    .brk_pat_i    (brk_pat),
    .brk_clr_i    (brk_clr),
    .pwm_i        (pwm_in),
    .pwm_o        (pwm_out),
    .brk_active_o (active),
    .cnt_hold_o   (cnt_hold),
    .arr_hold_o   (arr_hold),
    .dcr_hold_o   (dcr_hold),
    .mode_hold_o  (mode_hold),
    .brk_irq_o    (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_holds(input string req, input logic exp);
    chk(req, {cnt_hold, arr_hold, mode_hold, dcr_hold},
        exp ? 32'h7F : 32'h0);
  endtask

  task automatic sweep(input string req, input logic tripped);
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        brk_pat = p[NCH-1:0];
        pwm_in  = q[NCH-1:0];
        #1;
        chk(req, pwm_out, tripped ? p : q);
      end
    end
  endtask

  task automatic trip();
    brk_en = 1'b1;
    brk_n  = 1'b0;
    step(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; brk_n = 1'b1; brk_en = 1'b0; brk_pat = '0;
    brk_clr = 1'b0; pwm_in = 4'hA;
    step(3);
    // R1 reset state
    chk("R1 active", active, 0);
    chk("R1 irq", irq, 0);
    chk_holds("R1 holds", 1'b0);
    chk("R1 pwm", pwm_out, 4'hA);
    rst = 1'b0;
    step(1);

    // R9 pass-through sweep while idle
    sweep("R9 pass", 1'b0);

    // R3 disabled pin is ignored
    brk_en = 1'b0; brk_n = 1'b0; pwm_in = 4'h5; brk_pat = 4'hF;
    step(6);
    chk("R3 active", active, 0);
    chk("R3 irq", irq, 0);
    chk("R3 pwm", pwm_out, 4'h5);
    brk_n = 1'b1;
    step(3);

    // R2 exact latency
    brk_en = 1'b1; brk_n = 1'b0; brk_pat = 4'h9; pwm_in = 4'h6;
    step(1);
    chk("R2 edge1", active, 0);
    step(1);
    chk("R2 edge2", active, 0);
    chk("R10 no early irq", irq, 0);
    step(1);
    chk("R2 edge3", active, 1);
    chk("R10 irq pulse", irq, 1);
    chk_holds("R7 holds set", 1'b1);
    chk("R8 pattern", pwm_out, 4'h9);
    step(1);
    chk("R10 irq one cycle", irq, 0);

    // R8 full sweep while tripped
    sweep("R8 sweep", 1'b1);

    // R6 clear while pin still low
    brk_clr = 1'b1;
    step(1);
    brk_clr = 1'b0;
    chk("R6 stays set", active, 1);
    chk("R6 no new irq", irq, 0);

    // R4 sticky after pin high and enable low; R10 no irq on toggles
    brk_n = 1'b1;
    step(3);
    brk_n = 1'b0;
    step(1);
    chk("R10 toggle irq a", irq, 0);
    step(1);
    chk("R10 toggle irq b", irq, 0);
    step(1);
    chk("R10 toggle irq c", irq, 0);
    brk_n = 1'b1; brk_en = 1'b0;
    step(5);
    chk("R4 sticky", active, 1);
    chk_holds("R7 holds sticky", 1'b1);

    // R5 clear with pin high
    brk_clr = 1'b1;
    step(1);
    brk_clr = 1'b0;
    chk("R5 cleared", active, 0);
    chk_holds("R7 holds cleared", 1'b0);
    pwm_in = 4'h3; brk_pat = 4'hC;
    #1;
    chk("R9 after clear", pwm_out, 4'h3);

    // retrip gives a new interrupt
    brk_pat = 4'h2;
    step(1);
    trip();
    chk("R10 retrip irq", irq, 1);
    chk("R8 retrip pattern", pwm_out, 4'h2);
    brk_n = 1'b1;
    step(3);
    brk_clr = 1'b1;
    step(1);
    brk_clr = 1'b0;
    chk("R5 second clear", active, 0);
    step(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule